// File: doc/BRIEF.md
# Port-Mapped I/O Register Decoder

This block is a small peripheral on a simplified processor bus with an 8-bit address, an 8-bit data path and separate read and write strobes. It decodes a contiguous group of four port addresses at the top of the I/O space. Each port is backed by an 8-bit register. A write strobe loads the addressed register. A read strobe places the addressed register onto the shared read data.

The shared bus is modelled without tri-state logic. `bus_rdata` carries the value the bus would resolve to, and `bus_drive` says whether this block is driving it. When no port drives, `bus_rdata` is 0xFF, which models a bus that floats high.

The interface is a plain strobe bus. It has no valid/ready pair and no back-pressure: every strobe takes effect in the cycle it is presented.

Top module: `pio_port_block`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising clock edge clears all four port registers to 0x00.
- R2: With `bus_wr` high and `bus_addr` equal to 0xF8 + k (k = 0..3, taken from `bus_addr[1:0]`), port k takes `bus_wdata` at the next rising edge.
- R3: A write whose upper six address bits differ from 0b111110 changes no port register.
- R4: With `bus_rd` high, `bus_wr` low and `bus_addr` in 0xF8..0xFB, `bus_rdata` shows port k in the same cycle and `bus_drive` is 1.
- R5: While no port drives the bus, `bus_drive` is 0 and `bus_rdata` is 0xFF. This covers a cycle with no read strobe and a read from an unmatched address.
- R6: When `bus_rd` and `bus_wr` are both high, the write of R2 is performed and the bus is not driven in that cycle.
- R7: At most one port is enabled onto the bus in any cycle.
- R8: A write to one port leaves the other three ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Port address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Resolved bus value: the selected port, or 0xFF when undriven |
| bus_drive | output | 1 | High while a port drives the bus |

## Verification
Reads are purely combinational, so `bus_rdata` and `bus_drive` are due in the same cycle as the read strobe. The bench drives the inputs at a falling edge and samples one nanosecond later, before any rising edge. A write lands at the first rising edge after the strobe is presented. The bench therefore observes it through a read issued at the following falling edge, and the read is held off any rising edge so that it cannot disturb the state. The cases for ignored writes and simultaneous strobes are judged by reading every port back through the bus.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_ADDR_W    = 8;
  localparam int unsigned PIO_DATA_W    = 8;
  localparam int unsigned PIO_NUM_PORTS = 4;
  localparam logic [7:0]  PIO_BASE      = 8'hF8;

  function automatic bit base_is_aligned(input int unsigned base, input int unsigned ports);
    return (base % ports) == 0;
  endfunction
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode #(
  parameter int unsigned ADDR_W    = pio_pkg::PIO_ADDR_W,
  parameter int unsigned NUM_PORTS = pio_pkg::PIO_NUM_PORTS,
  parameter logic [ADDR_W-1:0] BASE = ADDR_W'(pio_pkg::PIO_BASE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic [NUM_PORTS-1:0] wr_en,
  output logic [NUM_PORTS-1:0] rd_en
);
  localparam int unsigned SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int unsigned TAG_W = ADDR_W - SEL_W;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SEL_W];

  logic             tag_hit;
  logic [SEL_W-1:0] idx;

  assign tag_hit = (addr[ADDR_W-1:SEL_W] == BASE_TAG);
  assign idx     = addr[SEL_W-1:0];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sel
    logic hit;
    assign hit      = tag_hit && (idx == SEL_W'(i));
    assign wr_en[i] = hit && wr;
    // a write wins over a read in the same cycle
    assign rd_en[i] = hit && rd && !wr;
  end

  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en)) else $error("more than one port enabled"); // R7
  AST_WR_BLOCKS_RD: assert property (@(posedge clk) disable iff (rst)
    wr |-> (rd_en == '0)) else $error("read enabled during write"); // R6
  AST_MISS_NO_EN: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1:SEL_W] != BASE_TAG) |-> (wr_en == '0 && rd_en == '0))
    else $error("unmatched address enabled a port"); // R3
endmodule

// File: rtl/pio_reg_bank.sv
module pio_reg_bank #(
  parameter int unsigned DATA_W    = pio_pkg::PIO_DATA_W,
  parameter int unsigned NUM_PORTS = pio_pkg::PIO_NUM_PORTS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS-1:0]           wr_en,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] regs
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           regs[i] <= '0;
      else if (wr_en[i]) regs[i] <= wdata;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (regs[i] == '0)) else $error("port not cleared"); // R1
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
      wr_en[i] |=> (regs[i] == $past(wdata))) else $error("write lost"); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !wr_en[i] |=> $stable(regs[i])) else $error("port changed unselected"); // R8
  end
endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive #(
  parameter int unsigned DATA_W    = pio_pkg::PIO_DATA_W,
  parameter int unsigned NUM_PORTS = pio_pkg::PIO_NUM_PORTS
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PORTS-1:0]             rd_en,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]                rdata,
  output logic                             drive
);
  logic [DATA_W-1:0] or_tree;

  // each port gates its value with its own enable, mimicking a tri-state driver
  always_comb begin
    or_tree = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      or_tree = or_tree | (regs[i] & {DATA_W{rd_en[i]}});
    end
  end

  assign drive = |rd_en;
  // an undriven bus is pulled high
  assign rdata = drive ? or_tree : '1;

  AST_FLOAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    !drive |-> (rdata == '1)) else $error("undriven bus not all ones"); // R5
endmodule

// File: rtl/pio_port_block.sv
module pio_port_block #(
  parameter int unsigned ADDR_W    = pio_pkg::PIO_ADDR_W,
  parameter int unsigned DATA_W    = pio_pkg::PIO_DATA_W,
  parameter int unsigned NUM_PORTS = pio_pkg::PIO_NUM_PORTS,
  parameter logic [ADDR_W-1:0] BASE = ADDR_W'(pio_pkg::PIO_BASE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_drive
);
  logic [NUM_PORTS-1:0]             wr_en;
  logic [NUM_PORTS-1:0]             rd_en;
  logic [NUM_PORTS-1:0][DATA_W-1:0] regs;

  initial begin
    if (!pio_pkg::base_is_aligned(int'(BASE), NUM_PORTS))
      $error("BASE must be aligned to NUM_PORTS");
  end

  pio_addr_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .BASE(BASE)) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  pio_reg_bank #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(bus_wdata), .regs(regs)
  );

  pio_bus_drive #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_drv (
    .clk(clk), .rst(rst), .rd_en(rd_en), .regs(regs),
    .rdata(bus_rdata), .drive(bus_drive)
  );

  AST_BOTH_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |-> !bus_drive) else $error("bus driven on rd+wr"); // R6
  AST_RD_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && (bus_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2])) |-> bus_drive)
    else $error("matched read not driven"); // R4
endmodule

// File: tb/tb_pio_port_block.sv
module tb_pio_port_block;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_drive;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [4];

  always #4 clk = ~clk;

  pio_port_block dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_drive(bus_drive)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic also_rd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = also_rd;
    #1;
    if (also_rd) check("R6 drive during rd+wr", {bus_drive, bus_rdata}, {1'b0, 8'hFF});
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input string req, input logic [8:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #1;
    check(req, {bus_drive, bus_rdata}, exp);
    bus_rd = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 4; k++) do_read(8'hF8 + 8'(k), req, {1'b1, model[k]});
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) model[k] = 8'h00;
    read_all("R1 reset value");
  endtask

  task automatic t_write_each();
    logic [7:0] pat [4] = '{8'h5A, 8'hA5, 8'h3C, 8'hC3};
    for (int k = 0; k < 4; k++) begin
      do_write(8'hF8 + 8'(k), pat[k], 1'b0);
      model[k] = pat[k];
      do_read(8'hF8 + 8'(k), "R2/R4 write then read", {1'b1, pat[k]});
    end
    read_all("R8 other ports kept");
  endtask

  task automatic t_isolation();
    do_write(8'hFA, 8'h00, 1'b0); model[2] = 8'h00;
    do_write(8'hF9, 8'hFF, 1'b0); model[1] = 8'hFF;
    read_all("R8 isolation");
  endtask

  task automatic t_unmatched_write();
    logic [7:0] miss [5] = '{8'hF7, 8'hFC, 8'h78, 8'hB8, 8'h00};
    for (int j = 0; j < 5; j++) do_write(miss[j], 8'h11, 1'b0);
    read_all("R3 unmatched write ignored");
  endtask

  task automatic t_unmatched_read();
    do_read(8'hF4, "R5 unmatched read", {1'b0, 8'hFF});
    do_read(8'h78, "R5 unmatched read", {1'b0, 8'hFF});
    do_read(8'hFF, "R5 unmatched read", {1'b0, 8'hFF});
  endtask

  task automatic t_idle();
    @(negedge clk);
    bus_addr = 8'hF9; bus_rd = 1'b0; bus_wr = 1'b0;
    #1;
    check("R5 idle bus", {bus_drive, bus_rdata}, {1'b0, 8'hFF});
  endtask

  task automatic t_both();
    do_write(8'hFB, 8'h96, 1'b1); model[3] = 8'h96;
    read_all("R6 rd+wr performs write");
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 4; k++) model[k] = 8'h00;
    read_all("R1 reset clears");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_each();
    t_isolation();
    t_unmatched_write();
    t_unmatched_read();
    t_idle();
    t_both();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule